// File: doc/BRIEF.md
# Toggle-Handshake Error Interrupt Controller

This block reports global error conditions to software and drives edge-triggered wired interrupt lines. Errors are not set and cleared as status bits. Hardware raises an error by flipping a bit in the error register. Software acknowledges it by writing the acknowledge register so that the same bit matches again. A bit is pending while the two registers hold different values.

Three request strobes arrive from the surrounding logic: event queue, command-sync completion and global error. A priority-request strobe is also accepted, but that source is not supported and never fires. A global-error request carries a mask, and only the masked bits that are not already pending are flipped. Each interrupt line is a registered single-cycle pulse.

A small register port gives software access to three registers. The error register is read-only. The acknowledge register and the interrupt control register can be read and written. Each write that toggles bits which were not pending raises an illegal-acknowledge flag for one cycle.

Top module: `gerr_irq_ctrl`

## Requirements
- R1: After reset the error register, the acknowledge register and the control register read zero, and every interrupt output, `ack_done` and `ack_illegal` are low.
- R2: A global-error request flips the bits of `gerr_mask & ~(err ^ ack)` in the error register at the next clock edge. Bits that are already pending keep their value.
- R3: A global-error request that flips no bit produces no `irq_gerr` pulse. This covers a zero mask and a mask whose bits are all pending.
- R4: When a global-error request flips at least one bit, `irq_gerr` pulses in the following cycle only if control bit 0 is set. The error register updates either way.
- R5: An event-queue request pulses `irq_evq` in the following cycle only if control bit 2 is set.
- R6: A command-sync request pulses `irq_cmdsync` in the following cycle whatever the control bits hold.
- R7: A priority-request strobe never produces a pulse on `irq_prireq`.
- R8: Every interrupt output is high for exactly one cycle per pulse. If a request arrives while its line is already high, one further pulse follows after a low cycle.
- R9: A write to address 1 loads the acknowledge register with the full write data. In the next cycle `ack_done` shows, for one cycle, the toggled bits that were pending.
- R10: A write to address 1 that toggles any bit that was not pending is still accepted in full, and `ack_illegal` is high for the following cycle.
- R11: When a global-error request and an acknowledge write happen in the same cycle, the request is evaluated against the pending bits from before the write.
- R12: The register map is address 0 for the error register (read-only, writes ignored), address 1 for the acknowledge register, and address 2 for the control register. The control register keeps only bit 0 (global-error enable) and bit 2 (event-queue enable), and its other bits read zero. `reg_rdata` follows `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evq_req | input | 1 | Event-queue interrupt request strobe |
| prireq_req | input | 1 | Priority-request strobe (unsupported) |
| cmdsync_req | input | 1 | Command-sync completion strobe |
| gerr_req | input | 1 | Global-error request strobe |
| gerr_mask | input | ERR_W | Error bits to raise with `gerr_req` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | ERR_W | Register write data |
| reg_rdata | output | ERR_W | Register read data |
| irq_evq | output | 1 | Event-queue interrupt pulse |
| irq_prireq | output | 1 | Priority-request interrupt pulse (stays low) |
| irq_cmdsync | output | 1 | Command-sync interrupt pulse |
| irq_gerr | output | 1 | Global-error interrupt pulse |
| err_reg | output | ERR_W | Error register value |
| ack_reg | output | ERR_W | Acknowledge register value |
| ack_done | output | ERR_W | Pending bits cleared by the last write, one cycle |
| ack_illegal | output | 1 | Last write toggled a non-pending bit, one cycle |

## Verification
A wrong pending vector shows up one cycle after a global-error request. Either `err_reg` re-flips a bit that was still pending, or `irq_gerr` pulses when nothing changed. A wrong acknowledge state shows in `ack_reg`, `ack_done` or `ack_illegal` right after the write edge. A pulse generator stuck high, or one that loses a back-to-back request, is visible within two cycles on its interrupt line. The same-cycle request-and-write case separates a design that uses the pre-write pending bits from one that uses the post-write bits.

// File: rtl/gerr_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the toggle-handshake error interrupt controller.
package gerr_irq_pkg;

    // Interrupt source index; also the order of the pulse generators.
    localparam int NUM_SRC  = 4;
    localparam int SRC_EVQ  = 0;
    localparam int SRC_PRI  = 1;
    localparam int SRC_SYNC = 2;
    localparam int SRC_GERR = 3;

    // Control register layout.
    localparam int CTRL_W       = 3;
    localparam int EN_GERR_BIT  = 0;
    localparam int EN_EVQ_BIT   = 2;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 3'b101;

    // Register addresses.
    localparam int ADDR_ERR  = 0;
    localparam int ADDR_ACK  = 1;
    localparam int ADDR_CTRL = 2;

endpackage

// File: rtl/irq_edge_pulse.sv
`timescale 1ns/1ps
// Turns fire requests into single-cycle pulses for an edge-sensitive wire.
// Assumes: fire is already gated by any enable. A fire that arrives while the
// pulse is high is owed (one deep) and emitted after one low cycle.
module irq_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    logic pulse_q;
    logic owed_q;

    // Emit a pulse when low and something is waiting; remember one overlapping fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            owed_q  <= 1'b0;
        end else if (pulse_q) begin
            pulse_q <= 1'b0;
            owed_q  <= owed_q | fire;
        end else begin
            pulse_q <= fire | owed_q;
            owed_q  <= fire & owed_q;
        end
    end

    assign pulse = pulse_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R8

endmodule

// File: rtl/gerr_toggle_unit.sv
`timescale 1ns/1ps
// Holds the error and acknowledge registers and computes the pending set.
// Hardware flips masked non-pending bits of the error register; software
// writes the acknowledge register in full. Both use pre-edge values.
module gerr_toggle_unit #(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_req,
    input  logic [ERR_W-1:0] hw_mask,
    input  logic             sw_wr,
    input  logic [ERR_W-1:0] sw_data,
    output logic [ERR_W-1:0] err_q,
    output logic [ERR_W-1:0] ack_q,
    output logic             flipped_any,
    output logic [ERR_W-1:0] acked_q,
    output logic             illegal_q
);

    logic [ERR_W-1:0] pending;
    logic [ERR_W-1:0] fresh;
    logic [ERR_W-1:0] toggled;

    // Pending bits, the bits a hardware request may flip, and the bits a write toggles.
    always_comb begin
        pending     = err_q ^ ack_q;
        fresh       = hw_req ? (hw_mask & ~pending) : '0;
        flipped_any = |fresh;
        toggled     = sw_wr ? (ack_q ^ sw_data) : '0;
    end

    // Update both registers and the one-cycle acknowledge reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= '0;
            ack_q     <= '0;
            acked_q   <= '0;
            illegal_q <= 1'b0;
        end else begin
            err_q     <= err_q ^ fresh;
            if (sw_wr) begin
                ack_q <= sw_data;
            end
            acked_q   <= toggled & pending;
            illegal_q <= |(toggled & ~pending);
        end
    end

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((err_q ^ $past(err_q)) & $past(pending)) == '0)); // R2

    AST_ACK_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (ack_q == $past(sw_data))); // R9

    AST_ILLEGAL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> $past(sw_wr)); // R10

endmodule

// File: rtl/gerr_reg_port.sv
`timescale 1ns/1ps
// Decodes the simple register port: write strobes for the acknowledge and
// control registers, storage for the control register, and the read mux.
// Assumes: reads are combinational, and the error register is read-only.
module gerr_reg_port
    import gerr_irq_pkg::*;
#(
    parameter int ERR_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ERR_W-1:0]  wdata,
    input  logic [ERR_W-1:0]  err_val,
    input  logic [ERR_W-1:0]  ack_val,
    output logic              ack_wr,
    output logic              en_gerr,
    output logic              en_evq,
    output logic [ERR_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(ADDR_ERR);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ADDR_ACK);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    logic [CTRL_W-1:0] ctrl_q;

    // Acknowledge write strobe.
    assign ack_wr = wr && (addr == A_ACK);

    // Control register keeps only its defined enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr && (addr == A_CTRL)) begin
            ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
        end
    end

    assign en_gerr = ctrl_q[EN_GERR_BIT];
    assign en_evq  = ctrl_q[EN_EVQ_BIT];

    // Read mux by address.
    always_comb begin
        case (addr)
            A_ERR:   rdata = err_val;
            A_ACK:   rdata = ack_val;
            A_CTRL:  rdata = {{(ERR_W-CTRL_W){1'b0}}, ctrl_q};
            default: rdata = '0;
        endcase
    end

    AST_CTRL_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CTRL) |=> (ctrl_q == ($past(wdata[CTRL_W-1:0]) & CTRL_KEEP))); // R12

endmodule

// File: rtl/gerr_irq_ctrl.sv
`timescale 1ns/1ps
// Toggle-handshake error interrupt controller, top level.
// Gates each source by its enable, then drives one pulse generator per
// source. Assumes: request inputs are single-cycle strobes from the same clock.
module gerr_irq_ctrl
    import gerr_irq_pkg::*;
#(
    parameter int   ERR_W         = 32,
    parameter int   ADDR_W        = 2,
    parameter logic PRI_SUPPORTED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evq_req,
    input  logic              prireq_req,
    input  logic              cmdsync_req,
    input  logic              gerr_req,
    input  logic [ERR_W-1:0]  gerr_mask,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [ERR_W-1:0]  reg_wdata,
    output logic [ERR_W-1:0]  reg_rdata,
    output logic              irq_evq,
    output logic              irq_prireq,
    output logic              irq_cmdsync,
    output logic              irq_gerr,
    output logic [ERR_W-1:0]  err_reg,
    output logic [ERR_W-1:0]  ack_reg,
    output logic [ERR_W-1:0]  ack_done,
    output logic              ack_illegal
);

    logic               ack_wr;
    logic               en_gerr;
    logic               en_evq;
    logic               flipped_any;
    logic [NUM_SRC-1:0] fire;
    logic [NUM_SRC-1:0] pulses;

    gerr_reg_port #(.ERR_W(ERR_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .err_val (err_reg),
        .ack_val (ack_reg),
        .ack_wr  (ack_wr),
        .en_gerr (en_gerr),
        .en_evq  (en_evq),
        .rdata   (reg_rdata)
    );

    gerr_toggle_unit #(.ERR_W(ERR_W)) u_toggle (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_req      (gerr_req),
        .hw_mask     (gerr_mask),
        .sw_wr       (ack_wr),
        .sw_data     (reg_wdata),
        .err_q       (err_reg),
        .ack_q       (ack_reg),
        .flipped_any (flipped_any),
        .acked_q     (ack_done),
        .illegal_q   (ack_illegal)
    );

    // Per-source fire conditions after enable gating.
    always_comb begin
        fire           = '0;
        fire[SRC_EVQ]  = evq_req & en_evq;
        fire[SRC_PRI]  = prireq_req & PRI_SUPPORTED;
        fire[SRC_SYNC] = cmdsync_req;
        fire[SRC_GERR] = flipped_any & en_gerr;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_edge_pulse u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire[i]),
            .pulse (pulses[i])
        );
    end

    assign irq_evq     = pulses[SRC_EVQ];
    assign irq_prireq  = pulses[SRC_PRI];
    assign irq_cmdsync = pulses[SRC_SYNC];
    assign irq_gerr    = pulses[SRC_GERR];

    AST_READ_CTRL_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADDR_CTRL)) |-> (reg_rdata[ERR_W-1:CTRL_W] == '0)); // R12

    AST_ERR_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !gerr_req |=> (err_reg == $past(err_reg))); // R12

endmodule

// File: tb/gerr_irq_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module gerr_irq_ctrl_bench;

    localparam int W  = 32;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evq_req = 1'b0, prireq_req = 1'b0, cmdsync_req = 1'b0, gerr_req = 1'b0;
    logic [W-1:0]  gerr_mask = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata, err_reg, ack_reg, ack_done;
    logic          irq_evq, irq_prireq, irq_cmdsync, irq_gerr, ack_illegal;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    gerr_irq_ctrl u_gerr_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evq_req(evq_req), .prireq_req(prireq_req),
        .cmdsync_req(cmdsync_req), .gerr_req(gerr_req), .gerr_mask(gerr_mask),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_evq(irq_evq), .irq_prireq(irq_prireq),
        .irq_cmdsync(irq_cmdsync), .irq_gerr(irq_gerr), .err_reg(err_reg),
        .ack_reg(ack_reg), .ack_done(ack_done), .ack_illegal(ack_illegal)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input int a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [W-1:0] d);
        reg_addr = AW'(a);
        #0.5;
        d = reg_rdata;
    endtask

    task automatic raise(input logic [W-1:0] m);
        gerr_req = 1'b1; gerr_mask = m;
        tick();
        gerr_req = 1'b0; gerr_mask = '0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        check("R1 err", err_reg, 0);
        check("R1 ack", ack_reg, 0);
        reg_read(2, v); check("R1 ctrl", v, 0);
        check("R1 irqs", {irq_evq, irq_prireq, irq_cmdsync, irq_gerr, ack_illegal}, 0);
        check("R1 ack_done", ack_done, 0);
    endtask

    task automatic t_regmap();
        logic [W-1:0] v;
        reg_write(2, 32'hFFFF_FFFF);
        reg_read(2, v); check("R12 ctrl keeps bits 0,2", v, 32'h5);
        reg_write(0, 32'h1234);
        check("R12 err write ignored", err_reg, 0);
        reg_read(0, v); check("R12 err read", v, 0);
        reg_write(2, 32'h1);
    endtask

    task automatic t_gerr_basic();
        raise(32'h3);
        check("R2 err flipped", err_reg, 32'h3);
        check("R4 gerr pulse enabled", irq_gerr, 1);
        tick();
        check("R8 gerr pulse one cycle", irq_gerr, 0);
    endtask

    task automatic t_gerr_suppress();
        raise(32'h6);
        check("R2 only non-pending flipped", err_reg, 32'h7);
        check("R2 pulse on partial flip", irq_gerr, 1);
        tick();
        raise(32'h3);
        check("R3 all pending no flip", err_reg, 32'h7);
        check("R3 no pulse all pending", irq_gerr, 0);
        raise(32'h0);
        check("R3 no pulse zero mask", irq_gerr, 0);
    endtask

    task automatic t_ack();
        reg_write(1, 32'h3);
        check("R9 ack loaded", ack_reg, 32'h3);
        check("R9 acked bits", ack_done, 32'h3);
        check("R10 legal write no flag", ack_illegal, 0);
        reg_write(1, 32'h13);
        check("R10 illegal write accepted", ack_reg, 32'h13);
        check("R10 illegal flag", ack_illegal, 1);
        check("R9 nothing acked", ack_done, 0);
        tick();
        check("R10 flag one cycle", ack_illegal, 0);
    endtask

    task automatic t_gerr_disabled();
        reg_write(2, 32'h4);
        raise(32'h100);
        check("R4 err flips while disabled", err_reg, 32'h107);
        check("R4 no pulse while disabled", irq_gerr, 0);
    endtask

    task automatic t_evq();
        evq_req = 1'b1; tick(); evq_req = 1'b0;
        check("R5 evq pulse enabled", irq_evq, 1);
        tick();
        reg_write(2, 32'h1);
        evq_req = 1'b1; tick(); evq_req = 1'b0;
        check("R5 evq no pulse disabled", irq_evq, 0);
    endtask

    task automatic t_sync_pri();
        reg_write(2, 32'h0);
        cmdsync_req = 1'b1; tick(); cmdsync_req = 1'b0;
        check("R6 cmdsync pulse enables off", irq_cmdsync, 1);
        reg_write(2, 32'h5);
        prireq_req = 1'b1; tick(); prireq_req = 1'b0;
        check("R7 prireq silent", irq_prireq, 0);
        tick();
        check("R7 prireq silent later", irq_prireq, 0);
    endtask

    task automatic t_back2back();
        tick();
        cmdsync_req = 1'b1; tick();
        check("R8 first pulse", irq_cmdsync, 1);
        tick(); cmdsync_req = 1'b0;
        check("R8 gap low", irq_cmdsync, 0);
        tick();
        check("R8 owed pulse", irq_cmdsync, 1);
        tick();
        check("R8 back low", irq_cmdsync, 0);
    endtask

    task automatic t_simultaneous();
        // bit 8 pending (err 0x107, ack 0x13); ack it and request it in one cycle
        reg_write(2, 32'h1);
        gerr_req = 1'b1; gerr_mask = 32'h100;
        reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 32'h113;
        tick();
        gerr_req = 1'b0; gerr_mask = '0; reg_wr = 1'b0;
        check("R11 err not flipped", err_reg, 32'h107);
        check("R11 ack taken", ack_reg, 32'h113);
        check("R11 no gerr pulse", irq_gerr, 0);
        check("R11 acked bit8", ack_done, 32'h100);
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regmap();
        t_gerr_basic();
        t_gerr_suppress();
        t_ack();
        t_gerr_disabled();
        t_evq();
        t_sync_pri();
        t_back2back();
        t_simultaneous();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule